// File: doc/BRIEF.md
# Dual-Protocol Parallel Host Port

This block is the host-facing front end of a character display controller. A microprocessor reaches it over one set of parallel bus pins. A strap input picks the bus style. In the enable style, one pin gives the transfer direction and a second pin is a high-active enable that qualifies the cycle. In the strobe style, the same two pins become a high-active write strobe and a low-active read strobe. All bus inputs pass through a synchronizer into the internal clock domain. Each cycle is then found from an edge of the synchronized strobe.

Completed writes are bytes for the instruction register or for the data register. The register-select line chooses between them. Each byte is offered to the controller core on a valid/ready stream and is held until the core takes it. Status reads show the core's busy flag and address counter. Data reads return an output register that the core fills after each read, so the first read after an address change gives stale data. The data path is 8 or 4 bits wide. In the 4-bit case the port joins two nibbles into one byte for writes and splits each byte into two nibbles for reads, high nibble first. The port decodes the width instruction itself, because it needs the width to track nibbles.

Top module: `hbp_host_port`

## Requirements
- R1: With `mode_enable_style` high, `host_dir` low means write. A write is taken at the falling edge of `host_strobe` while `host_cs_n` is low. It appears on `wr_byte`, with `wr_is_data` equal to `host_reg_sel` (1 = data register, 0 = instruction register).
- R2: With `mode_enable_style` low, `host_dir` is a high-active write strobe. The byte is taken on its falling edge while `host_cs_n` is low.
- R3: While `host_cs_n` is high, no write is produced and `host_d_oe` stays zero.
- R4: A read with `host_reg_sel` low returns the status byte {`core_busy`, 2'b00, `core_ac`}: bit 7 is busy and bits 4..0 are the address.
- R5: A read with `host_reg_sel` high returns the output register. The output register is zero after reset and loads only from `ram_q` when `ram_q_valid` is high. After each complete data-read byte, one request is raised on `rd_req_valid` and held until `rd_req_ready`. The first read therefore returns the earlier register value.
- R6: After reset the path is 8 bits wide. An instruction-register write of the byte 0000001x sets the width from bit 0 (1 = 8-bit, 0 = 4-bit) and restarts nibble tracking at the high nibble.
- R7: In 4-bit mode a write takes two transfers on bits 7..4, high nibble first. One byte is produced after the second transfer. Bits 3..0 of the bus are ignored.
- R8: In 4-bit mode a read gives the high nibble and then the low nibble on bits 7..4. `host_d_oe[3:0]` stays zero, and the data-read request follows only the second nibble.
- R9: A write byte stays on `wr_valid`/`wr_byte` unchanged until `wr_ready`. A bus write that completes while a byte is still pending is discarded.
- R10: `host_d_oe` is nonzero only during a selected read cycle. It is zero during writes and when the bus is idle.
- R11: With `mode_enable_style` low, `host_strobe` is a low-active read strobe. The selected byte is driven while it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low reset |
| mode_enable_style | input | 1 | Strap: 1 = enable plus direction, 0 = separate strobes |
| host_cs_n | input | 1 | Active-low chip select |
| host_reg_sel | input | 1 | 0 = instruction/status, 1 = data |
| host_dir | input | 1 | Direction (enable style) or write strobe (strobe style) |
| host_strobe | input | 1 | Enable (enable style) or low-active read strobe (strobe style) |
| host_d_in | input | 8 | Bus data from host |
| host_d_out | output | 8 | Bus data to host |
| host_d_oe | output | 8 | Per-line output enable for the bus |
| wr_valid | output | 1 | Write byte available |
| wr_ready | input | 1 | Core accepts write byte |
| wr_is_data | output | 1 | 1 = data register, 0 = instruction register |
| wr_byte | output | 8 | Assembled write byte |
| rd_req_valid | output | 1 | Request to fetch the next read byte |
| rd_req_ready | input | 1 | Core accepts fetch request |
| ram_q_valid | input | 1 | Load strobe for the output register |
| ram_q | input | 8 | Byte fetched by the core |
| core_busy | input | 1 | Busy flag for status reads |
| core_ac | input | AC_W | Address counter for status reads |

## Verification
Every bus input needs two clock edges to pass the synchronizer. Read drive and `host_d_oe` therefore follow a strobe change by two edges. A completed write shows on `wr_valid` one edge after that, and a data-read request shows on `rd_req_valid` at the same time. The bench holds every bus phase for six cycles and samples on the falling clock edge, well after each result is due. Write and request handshakes are counted by a monitor at the rising edge, so back-pressure cases can stall `wr_ready` and check that the held byte stays the same.

// File: rtl/hbp_pkg.sv
package hbp_pkg;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = BYTE_W / 2;

  typedef struct packed {
    logic              cs_n;
    logic              rs;
    logic              dir;
    logic              en;
    logic [BYTE_W-1:0] d;
  } hbp_bus_t;

  // Width-select instruction: 0000001x, bit 0 chooses 8-bit (1) or 4-bit (0)
  function automatic logic is_width_cmd(input logic [BYTE_W-1:0] b);
    return b[BYTE_W-1:1] == 7'b0000001;
  endfunction
endpackage

// File: rtl/hbp_sync.sv
module hbp_sync #(
  parameter int         W       = 12,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_prev
);
  logic [W-1:0] stg [STAGES+1];

  generate
    for (genvar i = 0; i <= STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      stg[i] <= RST_VAL;
        else if (i == 0) stg[i] <= d;
        else             stg[i] <= stg[i-1];
      end
    end
  endgenerate

  assign q      = stg[STAGES-1];
  assign q_prev = stg[STAGES];
endmodule

// File: rtl/hbp_cycle_decode.sv
module hbp_cycle_decode
  import hbp_pkg::*;
(
  input  logic     enable_style,
  input  hbp_bus_t cur,
  input  hbp_bus_t prev,
  output logic     write_done,
  output logic     read_done,
  output logic     read_active
);
  always_comb begin
    if (enable_style) begin
      write_done  = prev.en & ~cur.en & ~prev.dir & ~prev.cs_n;
      read_done   = prev.en & ~cur.en &  prev.dir & ~prev.cs_n;
      read_active = cur.en & cur.dir & ~cur.cs_n;
    end else begin
      write_done  = prev.dir & ~cur.dir & ~prev.cs_n;
      read_done   = ~prev.en & cur.en & ~prev.cs_n;
      read_active = ~cur.en & ~cur.cs_n;
    end
  end
endmodule

// File: rtl/hbp_nibble.sv
module hbp_nibble
  import hbp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer,
  input  logic              wide,
  input  logic              restart,
  input  logic [BYTE_W-1:0] d_full,
  output logic              phase_lo,
  output logic              byte_done,
  output logic [BYTE_W-1:0] byte_val
);
  logic [NIB_W-1:0] hi_hold;
  logic [NIB_W-1:0] d_hi;

  assign d_hi = d_full[BYTE_W-1:NIB_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_lo <= 1'b0;
      hi_hold  <= '0;
    end else if (restart) begin
      phase_lo <= 1'b0;
    end else if (xfer && !wide) begin
      if (!phase_lo) hi_hold <= d_hi;
      phase_lo <= ~phase_lo;
    end
  end

  assign byte_done = xfer & (wide | phase_lo);
  assign byte_val  = wide ? d_full : {hi_hold, d_hi};

  assert_alt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !wide && !restart) |=> (phase_lo != $past(phase_lo)));
endmodule

// File: rtl/hbp_host_port.sv
module hbp_host_port
  import hbp_pkg::*;
#(
  parameter int AC_W        = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_enable_style,
  input  logic              host_cs_n,
  input  logic              host_reg_sel,
  input  logic              host_dir,
  input  logic              host_strobe,
  input  logic [BYTE_W-1:0] host_d_in,
  output logic [BYTE_W-1:0] host_d_out,
  output logic [BYTE_W-1:0] host_d_oe,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic              wr_is_data,
  output logic [BYTE_W-1:0] wr_byte,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  input  logic              ram_q_valid,
  input  logic [BYTE_W-1:0] ram_q,
  input  logic              core_busy,
  input  logic [AC_W-1:0]   core_ac
);
  localparam int BUS_W = $bits(hbp_bus_t);
  localparam int PAD_W = BYTE_W - 1 - AC_W;
  localparam logic [BUS_W-1:0] BUS_IDLE = {1'b1, {(BUS_W-1){1'b0}}};

  hbp_bus_t raw, cur, prev;
  logic wdone, rdone, ractive;
  logic phase_lo, byte_done;
  logic [BYTE_W-1:0] byte_val;
  logic wide, width_set, wbyte_done, rbyte_done;
  logic [BYTE_W-1:0] out_reg, rsel;
  logic [NIB_W-1:0]  rnib;

  assign raw = {host_cs_n, host_reg_sel, host_dir, host_strobe, host_d_in};

  hbp_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL(BUS_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(cur), .q_prev(prev));

  hbp_cycle_decode u_dec (
    .enable_style(mode_enable_style), .cur(cur), .prev(prev),
    .write_done(wdone), .read_done(rdone), .read_active(ractive));

  hbp_nibble u_nib (
    .clk(clk), .rst_n(rst_n), .xfer(wdone | rdone), .wide(wide),
    .restart(width_set), .d_full(prev.d), .phase_lo(phase_lo),
    .byte_done(byte_done), .byte_val(byte_val));

  assign wbyte_done = byte_done & wdone;
  assign rbyte_done = byte_done & rdone;
  assign width_set  = wbyte_done & ~prev.rs & is_width_cmd(byte_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         wide <= 1'b1;
    else if (width_set) wide <= byte_val[0];
  end

  // Write hold register: one byte, discards new writes while occupied
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid   <= 1'b0;
      wr_is_data <= 1'b0;
      wr_byte    <= '0;
    end else begin
      if (wr_valid && wr_ready) wr_valid <= 1'b0;
      if (wbyte_done && (!wr_valid || wr_ready)) begin
        wr_valid   <= 1'b1;
        wr_is_data <= prev.rs;
        wr_byte    <= byte_val;
      end
    end
  end

  // Read fetch request and output register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_req_valid <= 1'b0;
      out_reg      <= '0;
    end else begin
      if (rd_req_valid && rd_req_ready) rd_req_valid <= 1'b0;
      if (rbyte_done && prev.rs)        rd_req_valid <= 1'b1;
      if (ram_q_valid)                  out_reg      <= ram_q;
    end
  end

  assign rsel = cur.rs ? out_reg : {core_busy, {PAD_W{1'b0}}, core_ac};
  assign rnib = phase_lo ? rsel[NIB_W-1:0] : rsel[BYTE_W-1:NIB_W];

  assign host_d_out = wide ? rsel : {rnib, {NIB_W{1'b0}}};
  assign host_d_oe  = {{NIB_W{ractive}}, {NIB_W{ractive & wide}}};

  assert_wr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_byte) && $stable(wr_is_data)));

  assert_rdreq_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> rd_req_valid);

  assert_wr_from_bus_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_valid) |-> $past(wdone));

  assert_width_by_instr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wide != $past(wide)) |-> ($past(wdone) && !$past(prev.rs)));

  assert_oe_needs_sel_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|host_d_oe) |-> !cur.cs_n);
endmodule

// File: tb/hbp_host_port_test.sv
module hbp_host_port_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode = 1'b1, cs_n = 1'b1, rs = 1'b0, dir = 1'b1, strb = 1'b0;
  logic [7:0] din = '0;
  logic [7:0] dout, doe;
  logic wr_valid, wr_is_data, rd_req_valid;
  logic wr_ready = 1'b1, rd_req_ready = 1'b1;
  logic [7:0] wr_byte;
  logic ram_q_valid = 1'b0;
  logic [7:0] ram_q = '0;
  logic busy = 1'b0;
  logic [4:0] ac = '0;

  int tests = 0, fails = 0;
  int wr_cnt = 0, rd_cnt = 0;
  logic [8:0] last_wr = '0;

  always #2 clk = ~clk;

  hbp_host_port uut (
    .clk(clk), .rst_n(rst_n), .mode_enable_style(mode), .host_cs_n(cs_n),
    .host_reg_sel(rs), .host_dir(dir), .host_strobe(strb), .host_d_in(din),
    .host_d_out(dout), .host_d_oe(doe), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_is_data(wr_is_data), .wr_byte(wr_byte), .rd_req_valid(rd_req_valid),
    .rd_req_ready(rd_req_ready), .ram_q_valid(ram_q_valid), .ram_q(ram_q),
    .core_busy(busy), .core_ac(ac));

  always @(posedge clk) begin
    if (wr_valid && wr_ready) begin
      wr_cnt  <= wr_cnt + 1;
      last_wr <= {wr_is_data, wr_byte};
    end
    if (rd_req_valid && rd_req_ready) rd_cnt <= rd_cnt + 1;
  end

  typedef struct packed {
    logic       m;
    logic       rsel;
    logic       rd;
    logic [7:0] val;
    logic [7:0] exp;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b1, 1'b0, 1'b0, 8'h38, 8'h38},
    '{1'b1, 1'b1, 1'b0, 8'hA5, 8'hA5},
    '{1'b0, 1'b0, 1'b0, 8'h0F, 8'h0F},
    '{1'b0, 1'b1, 1'b0, 8'h5A, 8'h5A},
    '{1'b1, 1'b0, 1'b1, 8'h93, 8'h93},
    '{1'b0, 1'b0, 1'b1, 8'h0A, 8'h0A},
    '{1'b1, 1'b0, 1'b1, 8'h1F, 8'h1F},
    '{1'b0, 1'b1, 1'b0, 8'hFF, 8'hFF}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic go_idle();
    cs_n = 1'b1;
    if (mode) begin strb = 1'b0; dir = 1'b1; end
    else      begin strb = 1'b1; dir = 1'b0; end
  endtask

  task automatic set_mode(input logic m);
    @(negedge clk);
    cs_n = 1'b1;
    mode = m;
    go_idle();
    wait_n(8);
  endtask

  task automatic bus_xfer(input logic sel, input logic r, input logic rd,
                          input logic [7:0] d, output logic [7:0] got,
                          output logic [7:0] oe_got);
    @(negedge clk);
    cs_n = ~sel; rs = r; din = d;
    if (mode) dir = rd;
    wait_n(4);
    if (mode)    strb = 1'b1;
    else if (rd) strb = 1'b0;
    else         dir  = 1'b1;
    wait_n(6);
    got = dout; oe_got = doe;
    if (mode)    strb = 1'b0;
    else if (rd) strb = 1'b1;
    else         dir  = 1'b0;
    wait_n(6);
    go_idle();
    wait_n(4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] g, o;
    int c0;
    go_idle();
    wait_n(3);
    check("R10 reset oe", {24'h0, doe}, 32'h0);
    check("R9 reset wr_valid", {31'h0, wr_valid}, 32'h0);
    check("R5 reset rd_req", {31'h0, rd_req_valid}, 32'h0);
    rst_n = 1'b1;
    wait_n(4);

    // R6: default width is 8-bit, all lines driven on a status read
    busy = 1'b0; ac = 5'h04;
    bus_xfer(1'b1, 1'b0, 1'b1, 8'h00, g, o);
    check("R6 default width oe", {24'h0, o}, 32'hFF);
    check("R4 status after reset", {24'h0, g}, 32'h04);

    for (int i = 0; i < 8; i++) begin
      vec_t v;
      v = VECS[i];
      set_mode(v.m);
      if (v.rd) begin
        busy = v.val[7]; ac = v.val[4:0];
        bus_xfer(1'b1, v.rsel, 1'b1, 8'h00, g, o);
        check(v.m ? "R4 status read" : "R11 status read", {24'h0, g}, {24'h0, v.exp});
        check("R10 oe in read", {24'h0, o}, 32'hFF);
      end else begin
        c0 = wr_cnt;
        bus_xfer(1'b1, v.rsel, 1'b0, v.val, g, o);
        check(v.m ? "R1 write count" : "R2 write count", wr_cnt, c0 + 1);
        check(v.m ? "R1 write byte" : "R2 write byte", {23'h0, last_wr}, {23'h0, v.rsel, v.exp});
        check("R10 oe in write", {24'h0, o}, 32'h0);
      end
    end

    // R3: deselected cycles
    set_mode(1'b1);
    c0 = wr_cnt;
    bus_xfer(1'b0, 1'b1, 1'b0, 8'h77, g, o);
    check("R3 no write when deselected", wr_cnt, c0);
    bus_xfer(1'b0, 1'b0, 1'b1, 8'h00, g, o);
    check("R3 no drive when deselected", {24'h0, o}, 32'h0);

    // R5: dummy read then valid read
    c0 = rd_cnt;
    bus_xfer(1'b1, 1'b1, 1'b1, 8'h00, g, o);
    check("R5 dummy read value", {24'h0, g}, 32'h00);
    check("R5 request after read", rd_cnt, c0 + 1);
    @(negedge clk); ram_q_valid = 1'b1; ram_q = 8'h41;
    @(negedge clk); ram_q_valid = 1'b0;
    bus_xfer(1'b1, 1'b1, 1'b1, 8'h00, g, o);
    check("R5 second read value", {24'h0, g}, 32'h41);

    // R9: back-pressure holds one byte, second write dropped
    set_mode(1'b0);
    @(negedge clk); wr_ready = 1'b0;
    c0 = wr_cnt;
    bus_xfer(1'b1, 1'b1, 1'b0, 8'h11, g, o);
    bus_xfer(1'b1, 1'b1, 1'b0, 8'h22, g, o);
    check("R9 held valid", {31'h0, wr_valid}, 32'h1);
    check("R9 held byte", {24'h0, wr_byte}, 32'h11);
    wr_ready = 1'b1;
    wait_n(4);
    check("R9 one accept", wr_cnt, c0 + 1);
    check("R9 accepted byte", {23'h0, last_wr}, {23'h0, 9'h111});
    check("R9 second dropped", {31'h0, wr_valid}, 32'h0);

    // R6: switch to 4-bit
    bus_xfer(1'b1, 1'b0, 1'b0, 8'h02, g, o);
    busy = 1'b1; ac = 5'h15;
    bus_xfer(1'b1, 1'b0, 1'b1, 8'h00, g, o);
    check("R8 status high nibble", {28'h0, g[7:4]}, 32'h9);
    check("R8 low lines undriven", {24'h0, o}, 32'hF0);
    bus_xfer(1'b1, 1'b0, 1'b1, 8'h00, g, o);
    check("R8 status low nibble", {28'h0, g[7:4]}, 32'h5);

    // R7: nibble write, junk on low lines
    c0 = wr_cnt;
    bus_xfer(1'b1, 1'b1, 1'b0, 8'hCA, g, o);
    check("R7 no byte after first nibble", wr_cnt, c0);
    bus_xfer(1'b1, 1'b1, 1'b0, 8'h75, g, o);
    check("R7 assembled byte", {23'h0, last_wr}, {23'h0, 9'h1C7});
    check("R7 one byte", wr_cnt, c0 + 1);

    // R8: nibble data read, request only after second nibble
    @(negedge clk); ram_q_valid = 1'b1; ram_q = 8'h3C;
    @(negedge clk); ram_q_valid = 1'b0;
    c0 = rd_cnt;
    bus_xfer(1'b1, 1'b1, 1'b1, 8'h00, g, o);
    check("R8 data high nibble", {28'h0, g[7:4]}, 32'h3);
    check("R8 no request mid byte", rd_cnt, c0);
    bus_xfer(1'b1, 1'b1, 1'b1, 8'h00, g, o);
    check("R8 data low nibble", {28'h0, g[7:4]}, 32'hC);
    check("R8 request after byte", rd_cnt, c0 + 1);

    // R6: back to 8-bit via nibbles 0 then 3
    bus_xfer(1'b1, 1'b0, 1'b0, 8'h0F, g, o);
    bus_xfer(1'b1, 1'b0, 1'b0, 8'h30, g, o);
    busy = 1'b0; ac = 5'h0B;
    bus_xfer(1'b1, 1'b0, 1'b1, 8'h00, g, o);
    check("R6 back to 8-bit oe", {24'h0, o}, 32'hFF);
    check("R6 back to 8-bit status", {24'h0, g}, 32'h0B);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule